// File: doc/BRIEF.md
# Serial Register Slave with Grouped Frequency Commit

This block is a byte-oriented slave for a two-wire, open-drain serial bus (I2C-compatible) that gives a host read and write access to a bank of 8-bit control registers. SCL and SDA are sampled by the much faster system clock. Each line passes through a two-flop synchroniser and a glitch filter whose length is derived from the system clock frequency. The block never drives SDA high. It only asserts an output enable that pulls the wire low, and it reads the resolved wire level back in.

A transfer opens with the 7-bit device address and a direction bit. On a write, the first byte after the address loads an internal register pointer and each further byte is stored at the pointer, which then advances. A read sets the pointer with a short write, then issues a repeated start with the read address and streams registers out from the pointer onwards. Four consecutive registers together form a 32-bit frequency word. Its output is held in a shadow and only changes when the top byte of the group is written, so that downstream logic never sees a partly updated word.

Top module: `i2c_reg_slave`

## Requirements
- R1: The block acknowledges only the address bytes whose upper seven bits equal 1101_01 followed by the strap input. With the strap low these are 0xD4 (write, bit 0 = 0) and 0xD5 (read, bit 0 = 1). Any other address is left unacknowledged.
- R2: Bytes move MSB first. The slave acknowledges by pulling SDA low (sdaOe = 1) for the ninth SCL pulse, and it only starts pulling SDA low while SCL is low.
- R3: In a write, the byte after the address sets the pointer. Each following byte is written to the pointed register, and the pointer then increments by one.
- R4: In a read started with a repeated start, bytes come from consecutive registers beginning at the pointer, while the master keeps acknowledging.
- R5: A pointer byte equal to or above the register count is not acknowledged, and the slave goes idle, so it also ignores the next byte.
- R6: A read burst that runs past the last register keeps returning the last register's value.
- R7: A write byte aimed past the last register is discarded and not acknowledged, and the slave goes idle.
- R8: A stop condition in the middle of a byte ends the transfer with no register change. A start condition in the middle of a byte restarts the address phase.
- R9: With the strap low, pulses on SDA or SCL shorter than the filter length (7 system clocks at 125 MHz, at least 50 ns) are removed. With the strap high, the filter is bypassed, so a 3-clock SDA dip while SCL is high is taken as a start followed by a stop.
- R10: Registers 4 to 7 form the frequency word, with register 4 as the least significant byte. freqWord changes only in the cycle after register 7 is written, and it then shows all four current register values.
- R11: An asynchronous active-low reset loads every register from its parameter default (register n = 0x11·(n+1) for n < 4, registers 4..7 = 0x1F,0x7C,0xF0,0x21, register n = 0x11·n for n ≥ 8), sets freqWord to 0x21F07C1F and releases SDA.
- R12: When the master does not acknowledge a read byte, the slave releases SDA and stays off the bus until the next stop or start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| addrStrap | input | 1 | Address bit 1; when high it also bypasses the glitch filter |
| sclIn | input | 1 | Serial clock line as seen at the pad |
| sdaIn | input | 1 | Resolved serial data line as seen at the pad |
| sdaOe | output | 1 | Pull SDA low when 1 |
| regFlat | output | REG_COUNT*8 | All register contents, register n at bits [8n+7:8n] |
| freqWord | output | 32 | Committed frequency word |

## Verification
The bench drives an open-drain bus model bit by bit and aims at the points where the protocol branches. It checks a pointer byte just out of range, and write and read bursts that run past register 15. A write design that wrapped its pointer would corrupt register 0, and a read design that wrapped would return register 0 after register 15. Stop and repeated start are placed in the middle of a byte, where a design without abort logic would write a half-shifted byte or lose address alignment. The frequency group is written in two separate transfers, so a design that committed byte by byte would show a mixed word after the first one. A 3-clock SDA dip is placed in mid-byte with the filter on and then off. Without filtering the dip silently ends the transfer, and with filtering forced on, the bypass case would wrongly acknowledge.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_SUB,
    ST_SUB_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RMACK,
    ST_WAIT_STOP
  } busState_t;

  // strobes from the protocol control to the register datapath
  typedef struct packed {
    logic shiftIn;   // capture one SDA bit into the receive shifter
    logic ptrLoad;   // load pointer from the received byte
    logic wrEn;      // store received byte at pointer, advance pointer
    logic txLoad;    // fetch register at pointer into transmit shifter
    logic txShift;   // present next transmit bit
  } dpStrobe_t;

  localparam logic [5:0] DEV_ADDR_HI = 6'b110101;

endpackage

// File: rtl/i2cs_glitch_filter.sv
module i2cs_glitch_filter #(
  parameter int FILT_CYCLES = 7
) (
  input  logic clk,
  input  logic rstN,
  input  logic bypass,
  input  logic rawIn,
  output logic cleanOut
);
  localparam int CNT_W = $clog2(FILT_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILT_CYCLES - 1);

  logic [1:0]       syncQ;
  logic [CNT_W-1:0] stableCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ     <= 2'b11;
      cleanOut  <= 1'b1;
      stableCnt <= '0;
    end else begin
      syncQ <= {syncQ[0], rawIn};
      if (bypass) begin
        cleanOut  <= syncQ[1];
        stableCnt <= '0;
      end else if (syncQ[1] == cleanOut) begin
        stableCnt <= '0;
      end else if (stableCnt == CNT_LAST) begin
        cleanOut  <= syncQ[1];
        stableCnt <= '0;
      end else begin
        stableCnt <= stableCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2cs_ctrl.sv
module i2cs_ctrl
  import i2cs_pkg::*;
#(
  parameter int REG_COUNT = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       strap,
  input  logic       sclF,
  input  logic       sdaF,
  input  logic [7:0] rxByte,
  input  logic       ptrValid,
  input  logic       txBit,
  output dpStrobe_t  strb,
  output logic       sdaOe,
  output busState_t  stateQ
);
  localparam logic [8:0] REG_COUNT9 = 9'(REG_COUNT);

  logic       sclQ, sdaQ;
  logic [3:0] bitCnt;
  logic       ackFlag, isRead, masterAck;

  logic sclRise, sclFall, startC, stopC, byteDone, addrOk, subOk;

  assign sclRise  = sclF & ~sclQ;
  assign sclFall  = ~sclF & sclQ;
  assign startC   = sclF & sclQ & sdaQ & ~sdaF;
  assign stopC    = sclF & sclQ & ~sdaQ & sdaF;
  assign byteDone = sclFall & (bitCnt == 4'd8);
  assign addrOk   = rxByte[7:1] == {DEV_ADDR_HI, strap};
  assign subOk    = {1'b0, rxByte} < REG_COUNT9;

  always_comb begin
    strb         = '0;
    strb.shiftIn = sclRise & (stateQ inside {ST_ADDR, ST_SUB, ST_WDATA});
    strb.ptrLoad = (stateQ == ST_SUB) & byteDone & subOk;
    strb.wrEn    = (stateQ == ST_WDATA) & byteDone & ptrValid;
    strb.txLoad  = sclFall & (((stateQ == ST_ADDR_ACK) & ackFlag & isRead) |
                              ((stateQ == ST_RMACK) & masterAck));
    strb.txShift = (stateQ == ST_RDATA) & sclFall & (bitCnt != 4'd8);
  end

  assign sdaOe = ((stateQ inside {ST_ADDR_ACK, ST_SUB_ACK, ST_WDATA_ACK}) & ackFlag) |
                 ((stateQ == ST_RDATA) & ~txBit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ    <= ST_IDLE;
      sclQ      <= 1'b1;
      sdaQ      <= 1'b1;
      bitCnt    <= '0;
      ackFlag   <= 1'b0;
      isRead    <= 1'b0;
      masterAck <= 1'b0;
    end else begin
      sclQ <= sclF;
      sdaQ <= sdaF;
      if (startC) begin
        stateQ <= ST_ADDR;
        bitCnt <= '0;
      end else if (stopC) begin
        stateQ <= ST_IDLE;
        bitCnt <= '0;
      end else begin
        unique case (stateQ)
          ST_ADDR, ST_SUB, ST_WDATA: begin
            if (sclRise) bitCnt <= bitCnt + 4'd1;
            if (byteDone) begin
              bitCnt <= '0;
              if (stateQ == ST_ADDR) begin
                stateQ  <= ST_ADDR_ACK;
                ackFlag <= addrOk;
                isRead  <= rxByte[0];
              end else if (stateQ == ST_SUB) begin
                stateQ  <= ST_SUB_ACK;
                ackFlag <= subOk;
              end else begin
                stateQ  <= ST_WDATA_ACK;
                ackFlag <= ptrValid;
              end
            end
          end
          ST_ADDR_ACK: if (sclFall) begin
            if (!ackFlag)    stateQ <= ST_IDLE;
            else if (isRead) stateQ <= ST_RDATA;
            else             stateQ <= ST_SUB;
          end
          ST_SUB_ACK, ST_WDATA_ACK: if (sclFall) begin
            stateQ <= ackFlag ? ST_WDATA : ST_IDLE;
          end
          ST_RDATA: begin
            if (sclRise) bitCnt <= bitCnt + 4'd1;
            if (byteDone) begin
              bitCnt <= '0;
              stateQ <= ST_RMACK;
            end
          end
          ST_RMACK: begin
            if (sclRise) masterAck <= ~sdaF;
            if (sclFall) stateQ <= masterAck ? ST_RDATA : ST_WAIT_STOP;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2cs_regbank.sv
module i2cs_regbank
  import i2cs_pkg::*;
#(
  parameter int REG_COUNT = 16,
  parameter int FREQ_BASE = 4,
  parameter logic [REG_COUNT*8-1:0] RESET_VALUES = '0
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   sdaF,
  input  dpStrobe_t              strb,
  output logic [7:0]             rxByte,
  output logic                   ptrValid,
  output logic                   txBit,
  output logic [REG_COUNT*8-1:0] regFlat,
  output logic [31:0]            freqWord
);
  localparam int PTR_W = $clog2(REG_COUNT + 1);
  localparam int IDX_W = $clog2(REG_COUNT);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(REG_COUNT - 1);
  localparam logic [PTR_W-1:0] PTR_END  = PTR_W'(REG_COUNT);
  localparam logic [PTR_W-1:0] PTR_FTOP = PTR_W'(FREQ_BASE + 3);

  logic [7:0]       regs [REG_COUNT];
  logic [PTR_W-1:0] ptr;
  logic [7:0]       txReg;
  logic [IDX_W-1:0] rdIdx;

  assign ptrValid = ptr < PTR_END;
  assign rdIdx    = ptrValid ? ptr[IDX_W-1:0] : IDX_W'(REG_COUNT - 1);
  assign txBit    = txReg[7];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte   <= '0;
      ptr      <= '0;
      txReg    <= 8'hFF;
      freqWord <= RESET_VALUES[FREQ_BASE*8 +: 32];
      for (int i = 0; i < REG_COUNT; i++) regs[i] <= RESET_VALUES[i*8 +: 8];
    end else begin
      if (strb.shiftIn) rxByte <= {rxByte[6:0], sdaF};
      if (strb.ptrLoad) ptr <= PTR_W'(rxByte);
      if (strb.wrEn) begin
        regs[ptr[IDX_W-1:0]] <= rxByte;
        ptr <= ptr + 1'b1;
        if (ptr == PTR_FTOP)
          freqWord <= {rxByte, regs[FREQ_BASE+2], regs[FREQ_BASE+1], regs[FREQ_BASE]};
      end
      if (strb.txLoad) begin
        txReg <= regs[rdIdx];
        if (ptrValid && ptr != PTR_LAST) ptr <= ptr + 1'b1;
      end else if (strb.txShift) begin
        txReg <= {txReg[6:0], 1'b1};
      end
    end
  end

  for (genvar g = 0; g < REG_COUNT; g++) begin : g_flat
    assign regFlat[g*8 +: 8] = regs[g];
  end
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave
  import i2cs_pkg::*;
#(
  parameter int SYS_CLK_MHZ = 125,
  parameter int REG_COUNT   = 16,
  parameter int FREQ_BASE   = 4,
  parameter logic [REG_COUNT*8-1:0] RESET_VALUES =
    128'hFFEEDDCC_BBAA9988_21F07C1F_44332211
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   addrStrap,
  input  logic                   sclIn,
  input  logic                   sdaIn,
  output logic                   sdaOe,
  output logic [REG_COUNT*8-1:0] regFlat,
  output logic [31:0]            freqWord
);
  // cycles covering at least 50 ns at the system clock
  localparam int FILT_RAW    = (SYS_CLK_MHZ * 50 + 999) / 1000;
  localparam int FILT_CYCLES = (FILT_RAW < 1) ? 1 : FILT_RAW;

  logic [1:0] rawLines, cleanLines;
  logic       sclClean, sdaClean;
  dpStrobe_t  strb;
  busState_t  ctrlState;
  logic [7:0] rxByte;
  logic       ptrValid, txBit;

  assign rawLines = {sclIn, sdaIn};
  for (genvar g = 0; g < 2; g++) begin : g_filt
    i2cs_glitch_filter #(.FILT_CYCLES(FILT_CYCLES)) u_filt (
      .clk(clk), .rstN(rstN), .bypass(addrStrap),
      .rawIn(rawLines[g]), .cleanOut(cleanLines[g])
    );
  end
  assign sclClean = cleanLines[1];
  assign sdaClean = cleanLines[0];

  i2cs_ctrl #(.REG_COUNT(REG_COUNT)) u_ctrl (
    .clk(clk), .rstN(rstN), .strap(addrStrap),
    .sclF(sclClean), .sdaF(sdaClean),
    .rxByte(rxByte), .ptrValid(ptrValid), .txBit(txBit),
    .strb(strb), .sdaOe(sdaOe), .stateQ(ctrlState)
  );

  i2cs_regbank #(
    .REG_COUNT(REG_COUNT), .FREQ_BASE(FREQ_BASE), .RESET_VALUES(RESET_VALUES)
  ) u_bank (
    .clk(clk), .rstN(rstN), .sdaF(sdaClean), .strb(strb),
    .rxByte(rxByte), .ptrValid(ptrValid), .txBit(txBit),
    .regFlat(regFlat), .freqWord(freqWord)
  );
endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker
  import i2cs_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        sclF,
  input logic        sdaOe,
  input busState_t   state,
  input logic        wrEn,
  input logic        ptrValid,
  input logic [31:0] freqWord,
  input logic [31:0] freqRegs
);
  assert_wr_in_range_R7: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> ptrValid);

  assert_freq_after_write_R10: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(freqWord) |-> $past(wrEn));

  assert_freq_whole_group_R10: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(freqWord) |-> (freqWord == freqRegs));

  assert_idle_release_R12: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE || state == ST_WAIT_STOP) |-> !sdaOe);

  assert_drive_scl_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !sclF);
endmodule

bind i2c_reg_slave i2cs_checker u_checker (
  .clk(clk), .rstN(rstN), .sclF(sclClean), .sdaOe(sdaOe), .state(ctrlState),
  .wrEn(strb.wrEn), .ptrValid(ptrValid), .freqWord(freqWord),
  .freqRegs(regFlat[FREQ_BASE*8 +: 32])
);

// File: tb/test_i2c_reg_slave.sv
module test_i2c_reg_slave;
  localparam int Q = 16;
  localparam logic [127:0] DEFAULTS = 128'hFFEEDDCC_BBAA9988_21F07C1F_44332211;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic strap = 1'b0;
  logic scl = 1'b1;
  logic sdaM = 1'b1;
  logic sdaOe;
  logic [127:0] regFlat;
  logic [31:0] freqWord;
  wire sdaBus = sdaM & ~sdaOe;

  int checks = 0;
  int failures = 0;
  logic [7:0] model [16];

  always #4 clk = ~clk;

  i2c_reg_slave i_i2c_reg_slave (
    .clk(clk), .rstN(rstN), .addrStrap(strap), .sclIn(scl), .sdaIn(sdaBus),
    .sdaOe(sdaOe), .regFlat(regFlat), .freqWord(freqWord)
  );

  task automatic checkEq(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkRegs(string tag);
    logic [127:0] exp;
    for (int i = 0; i < 16; i++) exp[i*8 +: 8] = model[i];
    checks++;
    if (regFlat !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, regFlat, exp);
    end
  endtask

  task automatic waitq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitq(); scl = 1'b1; waitq(); sdaM = 1'b0; waitq(); scl = 1'b0; waitq();
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitq(); scl = 1'b1; waitq(); sdaM = 1'b1; waitq();
  endtask

  task automatic sendBits(logic [7:0] b, int n);
    for (int i = 7; i > 7 - n; i--) begin
      sdaM = b[i]; waitq(); scl = 1'b1; waitq(); waitq(); scl = 1'b0; waitq();
    end
  endtask

  task automatic ackSlot(output logic ack);
    sdaM = 1'b1; waitq(); scl = 1'b1; waitq(); ack = sdaBus; waitq(); scl = 1'b0; waitq();
  endtask

  task automatic writeExpect(logic [7:0] b, logic expAck, string tag);
    logic ack;
    sendBits(b, 8);
    ackSlot(ack);
    checkEq(tag, {31'd0, ack}, {31'd0, expAck});
  endtask

  // first bit carries a 3-clock SDA dip while SCL is high
  task automatic writeGlitch(logic [7:0] b, logic expAck, string tag);
    logic ack;
    sdaM = b[7]; waitq(); scl = 1'b1; waitq();
    sdaM = 1'b0; repeat (3) @(negedge clk); sdaM = b[7];
    waitq(); scl = 1'b0; waitq();
    for (int i = 6; i >= 0; i--) begin
      sdaM = b[i]; waitq(); scl = 1'b1; waitq(); waitq(); scl = 1'b0; waitq();
    end
    ackSlot(ack);
    checkEq(tag, {31'd0, ack}, {31'd0, expAck});
  endtask

  task automatic readByte(logic giveAck, output logic [7:0] b);
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitq(); scl = 1'b1; waitq(); b[i] = sdaBus; waitq(); scl = 1'b0;
    end
    waitq(); sdaM = ~giveAck; waitq(); scl = 1'b1; waitq(); waitq(); scl = 1'b0; waitq();
    sdaM = 1'b1;
  endtask

  task automatic readExpect(logic giveAck, logic [7:0] exp, string tag);
    logic [7:0] b;
    readByte(giveAck, b);
    checkEq(tag, {24'd0, b}, {24'd0, exp});
  endtask

  task automatic t_reset();
    checkRegs("R11 register defaults");
    checkEq("R11 freqWord default", freqWord, 32'h21F07C1F);
    checkEq("R11 SDA released", {31'd0, sdaOe}, 32'd0);
  endtask

  task automatic t_wrongAddr();
    busStart();
    writeExpect(8'hD6, 1'b1, "R1 foreign address nack");
    busStop();
    busStart();
    writeExpect(8'hD4, 1'b0, "R1 own address ack");
    busStop();
    checkRegs("R1 no register change");
  endtask

  task automatic t_burstWrite();
    busStart();
    writeExpect(8'hD4, 1'b0, "R3 address ack");
    writeExpect(8'h02, 1'b0, "R3 pointer ack");
    writeExpect(8'h5A, 1'b0, "R3 data0 ack");
    writeExpect(8'hC3, 1'b0, "R3 data1 ack");
    busStop();
    model[2] = 8'h5A; model[3] = 8'hC3;
    checkRegs("R3 R2 burst write");
  endtask

  task automatic t_burstRead();
    busStart();
    writeExpect(8'hD4, 1'b0, "R4 address ack");
    writeExpect(8'h02, 1'b0, "R4 pointer ack");
    busStart();
    writeExpect(8'hD5, 1'b0, "R4 read address ack");
    readExpect(1'b1, 8'h5A, "R4 R2 read reg2");
    readExpect(1'b1, 8'hC3, "R4 read reg3");
    readExpect(1'b0, 8'h1F, "R4 read reg4");
    busStop();
  endtask

  task automatic t_invalidSub();
    busStart();
    writeExpect(8'hD4, 1'b0, "R5 address ack");
    writeExpect(8'h10, 1'b1, "R5 out-of-map pointer nack");
    writeExpect(8'h77, 1'b1, "R5 idle after nack");
    busStop();
    checkRegs("R5 no register change");
  endtask

  task automatic t_writeOverrun();
    busStart();
    writeExpect(8'hD4, 1'b0, "R7 address ack");
    writeExpect(8'h0E, 1'b0, "R7 pointer ack");
    writeExpect(8'hE1, 1'b0, "R7 reg14 ack");
    writeExpect(8'hE2, 1'b0, "R7 reg15 ack");
    writeExpect(8'hE3, 1'b1, "R7 overrun nack");
    writeExpect(8'hE4, 1'b1, "R7 idle after overrun");
    busStop();
    model[14] = 8'hE1; model[15] = 8'hE2;
    checkRegs("R7 overrun byte discarded");
  endtask

  task automatic t_readOverrun();
    busStart();
    writeExpect(8'hD4, 1'b0, "R6 address ack");
    writeExpect(8'h0E, 1'b0, "R6 pointer ack");
    busStart();
    writeExpect(8'hD5, 1'b0, "R6 read address ack");
    readExpect(1'b1, 8'hE1, "R6 read reg14");
    readExpect(1'b1, 8'hE2, "R6 read reg15");
    readExpect(1'b1, 8'hE2, "R6 repeat last");
    readExpect(1'b0, 8'hE2, "R6 repeat last again");
    busStop();
  endtask

  task automatic t_freq();
    busStart();
    writeExpect(8'hD4, 1'b0, "R10 address ack");
    writeExpect(8'h04, 1'b0, "R10 pointer ack");
    writeExpect(8'h11, 1'b0, "R10 byte0 ack");
    writeExpect(8'h22, 1'b0, "R10 byte1 ack");
    writeExpect(8'h33, 1'b0, "R10 byte2 ack");
    busStop();
    model[4] = 8'h11; model[5] = 8'h22; model[6] = 8'h33;
    checkRegs("R10 lower bytes stored");
    checkEq("R10 word held before top byte", freqWord, 32'h21F07C1F);
    busStart();
    writeExpect(8'hD4, 1'b0, "R10 address ack 2");
    writeExpect(8'h07, 1'b0, "R10 pointer ack 2");
    writeExpect(8'h44, 1'b0, "R10 top byte ack");
    busStop();
    model[7] = 8'h44;
    checkEq("R10 word committed", freqWord, 32'h44332211);
  endtask

  task automatic t_abort();
    busStart();
    writeExpect(8'hD4, 1'b0, "R8 address ack");
    writeExpect(8'h08, 1'b0, "R8 pointer ack");
    sendBits(8'h0F, 4);
    busStop();
    checkRegs("R8 stop mid-byte no write");
    busStart();
    sendBits(8'hD4, 3);
    busStart();
    writeExpect(8'hD4, 1'b0, "R8 restart address ack");
    writeExpect(8'h08, 1'b0, "R8 restart pointer ack");
    writeExpect(8'h3C, 1'b0, "R8 restart data ack");
    busStop();
    model[8] = 8'h3C;
    checkRegs("R8 write after restart");
  endtask

  task automatic t_masterNack();
    int driven = 0;
    busStart();
    writeExpect(8'hD4, 1'b0, "R12 address ack");
    writeExpect(8'h00, 1'b0, "R12 pointer ack");
    busStart();
    writeExpect(8'hD5, 1'b0, "R12 read address ack");
    readExpect(1'b0, 8'h11, "R12 read reg0 then nack");
    for (int i = 0; i < 3; i++) begin
      waitq(); scl = 1'b1; waitq(); if (sdaOe) driven++; waitq(); scl = 1'b0;
      if (sdaOe) driven++;
    end
    checkEq("R12 SDA stays released", driven, 0);
    waitq();
    busStop();
  endtask

  task automatic t_glitch();
    strap = 1'b0; waitq();
    busStart();
    writeExpect(8'hD4, 1'b0, "R9 filtered address ack");
    writeExpect(8'h09, 1'b0, "R9 filtered pointer ack");
    writeGlitch(8'hA5, 1'b0, "R9 dip removed, byte acked");
    busStop();
    model[9] = 8'hA5;
    checkRegs("R9 filtered write stored");
    strap = 1'b1; waitq();
    busStart();
    writeExpect(8'hD4, 1'b1, "R1 strap high rejects 0xD4");
    busStop();
    busStart();
    writeExpect(8'hD6, 1'b0, "R1 strap high accepts 0xD6");
    writeExpect(8'h09, 1'b0, "R9 bypass pointer ack");
    writeGlitch(8'h96, 1'b1, "R9 bypass dip ends transfer");
    busStop();
    checkRegs("R9 bypass byte not stored");
    strap = 1'b0; waitq();
  endtask

  initial begin
    for (int i = 0; i < 16; i++) model[i] = DEFAULTS[i*8 +: 8];
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    waitq();
    t_reset();
    t_wrongAddr();
    t_burstWrite();
    t_burstRead();
    t_invalidSub();
    t_writeOverrun();
    t_readOverrun();
    t_freq();
    t_abort();
    t_masterNack();
    t_glitch();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog (all requirements) actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule